// File: doc/BRIEF.md
# Selective Readout Flag Generator

This block decides, one event at a time, which trigger towers of a calorimeter grid are read out at full precision and which are read out zero-suppressed. A trigger accept captures the coarse transverse-energy sum of every tower in a ROWS x COLS grid. It also captures the current low and high thresholds in the same cycle. Each tower is then classified as suppressed, single, neighbor or center, and one 2-bit readout flag per tower is streamed out in raster order.

Accepts that arrive while an event is still streaming are held in a small queue. When that queue is full, a busy output tells the trigger source to throttle. The latency from an accept to the first flag is fixed when the block is idle. Each event then occupies the output for exactly one beat per tower.

Top module: `srflag_gen`

## Requirements
- R1: The tower sums and both thresholds are sampled in the clock cycle where trigAccept is seen. Changing towerEt, lowThr or highThr after that cycle has no effect on that event's flags.
- R2: A tower whose sum is greater than or equal to the high threshold gets flag code 2'b11 (center).
- R3: A tower whose sum is at least the low threshold and below the high threshold, and which has no center in its window, gets flag code 2'b01 (single).
- R4: A tower that is not a center but has a center among the up to eight towers of the 3x3 square around it gets flag code 2'b10 (neighbor). This code wins over single. Window positions beyond the grid edge are ignored.
- R5: Every other tower gets flag code 2'b00 (suppressed).
- R6: An event is sent as ROWS*COLS back-to-back beats with flagValid high. Beat k carries tower k, where k = row*COLS + col, and tower k's sum sits at towerEt[k*ET_W +: ET_W]. flagEnd is high on the last beat only, and at least one cycle without flagValid follows it.
- R7: With the block idle and no event queued, flagValid first rises on the second rising clock edge after the edge that samples trigAccept.
- R8: Accepts that arrive while an event is being processed are queued, up to QDEPTH of them, and emitted in arrival order.
- R9: busy is high exactly while QDEPTH events are waiting. An accept seen while busy is high is discarded and produces no flags.
- R10: While and after reset, flagValid, flagEnd and busy are low until an accept arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigAccept | input | 1 | One-cycle trigger accept strobe |
| towerEt | input | ROWS*COLS*ET_W | Tower sums, raster order, tower k at bits k*ET_W upward |
| lowThr | input | ET_W | Low classification threshold |
| highThr | input | ET_W | High classification threshold |
| flagOut | output | 2 | Readout flag of the current tower |
| flagValid | output | 1 | flagOut carries a tower flag |
| flagEnd | output | 1 | Last tower of the event |
| busy | output | 1 | Queue full, further accepts are dropped |

## Verification
Two things can happen in the same clock edge: an incoming accept is pushed into the queue while the control pops the oldest queued event to start processing it. The same holds for an accept arriving on the edge where the queue becomes full. The bench provokes both with a burst of accepts on consecutive cycles, each carrying a different tower map. It then judges the outcome by comparing every streamed flag against the map of the event it belongs to, and by checking that the number of events leaving equals the number that were not dropped.

// File: rtl/srfg_pkg.sv
package srfg_pkg;
  typedef enum logic [1:0] {
    FLAG_SUPP   = 2'b00,
    FLAG_SINGLE = 2'b01,
    FLAG_NEIGH  = 2'b10,
    FLAG_CENTER = 2'b11
  } srFlag_e;

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new event from the queue
    logic emit;   // send the flag of towerIdx
    logic last;   // this emit is the final tower
  } ctlStrobe_t;
endpackage

// File: rtl/srfg_queue.sv
module srfg_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = store[rdPtr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wrData;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> count == $past(count));
endmodule

// File: rtl/srfg_ctrl.sv
module srfg_ctrl
  import srfg_pkg::*;
#(
  parameter int NUM_TOWERS = 16,
  parameter int IDX_W      = $clog2(NUM_TOWERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qEmpty,
  output logic             qPop,
  output ctlStrobe_t       ctl,
  output logic [IDX_W-1:0] towerIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TOWERS - 1);

  ctlState_e state;

  always_comb begin
    ctl.load = (state == ST_IDLE) && !qEmpty;
    ctl.emit = (state == ST_RUN);
    ctl.last = (state == ST_RUN) && (towerIdx == LAST_IDX);
    qPop     = ctl.load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      towerIdx <= '0;
    end else if (state == ST_IDLE) begin
      if (ctl.load) begin
        state    <= ST_RUN;
        towerIdx <= '0;
      end
    end else if (ctl.last) begin
      state    <= ST_IDLE;
      towerIdx <= '0;
    end else begin
      towerIdx <= towerIdx + 1'b1;
    end
  end

  // R6
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.emit && !ctl.last |=> ctl.emit && towerIdx == $past(towerIdx) + 1'b1);
endmodule

// File: rtl/srfg_datapath.sv
module srfg_datapath
  import srfg_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int ET_W  = 8,
  parameter int IDX_W = $clog2(ROWS * COLS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctlStrobe_t                ctl,
  input  logic [IDX_W-1:0]          towerIdx,
  input  logic [ROWS*COLS*ET_W-1:0] evData,
  input  logic [ET_W-1:0]           evLow,
  input  logic [ET_W-1:0]           evHigh,
  output logic [1:0]                flagOut,
  output logic                      flagValid,
  output logic                      flagEnd
);
  localparam int NUM = ROWS * COLS;

  logic [NUM-1:0][ET_W-1:0] etReg;
  logic [ET_W-1:0]          lowR, highR;
  logic [NUM-1:0]           isCenter;
  logic [NUM-1:0][1:0]      flagsAll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      etReg <= '0;
      lowR  <= '0;
      highR <= '0;
    end else if (ctl.load) begin
      etReg <= evData;
      lowR  <= evLow;
      highR <= evHigh;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [8:0] win;
      assign isCenter[IDX] = (etReg[IDX] >= highR);
      for (genvar k = 0; k < 9; k++) begin : g_win
        localparam int RR = r + k / 3 - 1;
        localparam int CC = c + k % 3 - 1;
        if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
          assign win[k] = isCenter[RR * COLS + CC];
        end else begin : g_out
          assign win[k] = 1'b0;
        end
      end
      assign flagsAll[IDX] = isCenter[IDX]          ? FLAG_CENTER :
                             (|win)                 ? FLAG_NEIGH  :
                             (etReg[IDX] >= lowR)   ? FLAG_SINGLE : FLAG_SUPP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagOut   <= '0;
      flagValid <= 1'b0;
      flagEnd   <= 1'b0;
    end else begin
      flagOut   <= ctl.emit ? flagsAll[towerIdx] : 2'b00;
      flagValid <= ctl.emit;
      flagEnd   <= ctl.last;
    end
  end

  // R1
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.emit |=> !ctl.emit || ($stable(lowR) && $stable(highR) && $stable(etReg)));
  // R6
  end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flagEnd |-> flagValid);
  // R6
  end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flagEnd |=> !flagValid);
endmodule

// File: rtl/srflag_gen.sv
module srflag_gen #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int ET_W   = 8,
  parameter int QDEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trigAccept,
  input  logic [ROWS*COLS*ET_W-1:0] towerEt,
  input  logic [ET_W-1:0]           lowThr,
  input  logic [ET_W-1:0]           highThr,
  output logic [1:0]                flagOut,
  output logic                      flagValid,
  output logic                      flagEnd,
  output logic                      busy
);
  import srfg_pkg::*;

  localparam int NUM   = ROWS * COLS;
  localparam int IDX_W = $clog2(NUM);
  localparam int MAP_W = NUM * ET_W;
  localparam int ENT_W = MAP_W + 2 * ET_W;

  logic [ENT_W-1:0] qIn, qOut;
  logic             qEmpty, qFull, qPop;
  ctlStrobe_t       ctl;
  logic [IDX_W-1:0] towerIdx;

  assign qIn  = {towerEt, lowThr, highThr};
  assign busy = qFull;

  srfg_queue #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(trigAccept), .wrData(qIn),
    .pop(qPop), .rdData(qOut), .empty(qEmpty), .full(qFull)
  );

  srfg_ctrl #(.NUM_TOWERS(NUM), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .qEmpty(qEmpty), .qPop(qPop),
    .ctl(ctl), .towerIdx(towerIdx)
  );

  srfg_datapath #(.ROWS(ROWS), .COLS(COLS), .ET_W(ET_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .towerIdx(towerIdx),
    .evData(qOut[2*ET_W +: MAP_W]), .evLow(qOut[ET_W +: ET_W]),
    .evHigh(qOut[0 +: ET_W]),
    .flagOut(flagOut), .flagValid(flagValid), .flagEnd(flagEnd)
  );
endmodule

// File: tb/srflag_gen_tb_top.sv
module srflag_gen_tb_top;
  localparam int ROWS = 4, COLS = 4, ET_W = 8, QDEPTH = 2, N = ROWS * COLS;

  logic clk = 1'b0, rst_n = 1'b0, trigAccept = 1'b0;
  logic [N*ET_W-1:0] towerEt = '0;
  logic [ET_W-1:0] lowThr = '0, highThr = '0;
  logic [1:0] flagOut;
  logic flagValid, flagEnd, busy;

  int checks = 0, errors = 0, evIn = 0, evOut = 0, beat = 0, cycles = 0;
  logic [1:0] expMem [64][N];
  logic [1:0] expCur;
  int curMap [N];

  always #5 clk = ~clk;

  srflag_gen #(.ROWS(ROWS), .COLS(COLS), .ET_W(ET_W), .QDEPTH(QDEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .trigAccept(trigAccept), .towerEt(towerEt),
    .lowThr(lowThr), .highThr(highThr), .flagOut(flagOut),
    .flagValid(flagValid), .flagEnd(flagEnd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [1:0] f);
    case (f)
      2'b11:   return "R2 center";
      2'b01:   return "R3 single";
      2'b10:   return "R4 neighbor";
      default: return "R5 suppressed";
    endcase
  endfunction

  function automatic logic [1:0] refFlag(input int r, input int c, input int lo, input int hi);
    if (curMap[r*COLS+c] >= hi) return 2'b11;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        int rr = r + dr;
        int cc = c + dc;
        if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS && curMap[rr*COLS+cc] >= hi)
          return 2'b10;
      end
    if (curMap[r*COLS+c] >= lo) return 2'b01;
    return 2'b00;
  endfunction

  // drive one accept from curMap; caller is at a falling edge
  task automatic arm(input int lo, input int hi, input bit accepted);
    for (int i = 0; i < N; i++) towerEt[i*ET_W +: ET_W] = ET_W'(curMap[i]);
    lowThr = ET_W'(lo);
    highThr = ET_W'(hi);
    trigAccept = 1'b1;
    if (accepted) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          expMem[evIn%64][r*COLS+c] = refFlag(r, c, lo, hi);
      evIn++;
    end
  endtask

  task automatic single_event(input int lo, input int hi);
    @(negedge clk);
    arm(lo, hi, 1'b1);
    @(negedge clk);
    trigAccept = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (evOut != evIn && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  // output monitor: every beat is compared with the event it belongs to
  always @(negedge clk) begin
    if (rst_n && flagValid) begin
      expCur = expMem[evOut%64][beat];
      check(flagOut == expCur, tagFor(expCur), int'(flagOut), int'(expCur));
      check(flagEnd == (beat == N - 1), "R6 end marker", int'(flagEnd), int'(beat == N - 1));
      if (beat == N - 1) begin
        beat = 0;
        evOut++;
      end else beat++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      summary();
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(flagValid == 1'b0, "R10 valid", int'(flagValid), 0);
    check(flagEnd == 1'b0, "R10 end", int'(flagEnd), 0);
    check(busy == 1'b0, "R10 busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(flagValid == 1'b0, "R10 valid after reset", int'(flagValid), 0);

    // R7 latency from an idle block
    for (int i = 0; i < N; i++) curMap[i] = (i == 5) ? 250 : 0;
    @(negedge clk);
    arm(40, 200, 1'b1);
    @(negedge clk);
    trigAccept = 1'b0;
    check(flagValid == 1'b0, "R7 one edge", int'(flagValid), 0);
    @(negedge clk);
    check(flagValid == 1'b0, "R7 one edge more", int'(flagValid), 0);
    @(negedge clk);
    check(flagValid == 1'b1, "R7 second edge", int'(flagValid), 1);
    drain();

    // R2..R5 sweep of the center over every grid position, incl. edges and corners
    for (int cp = 0; cp < N; cp++) begin
      for (int i = 0; i < N; i++) curMap[i] = (i * 29 + cp * 11) % 190;
      curMap[cp] = 200;
      single_event(40, 200);
      drain();
    end

    // threshold boundaries: sums equal to low, one below low, equal to high
    for (int i = 0; i < N; i++) curMap[i] = (i % 2 == 1) ? 40 : 39;
    curMap[15] = 200;
    single_event(40, 200);
    drain();
    for (int i = 0; i < N; i++) curMap[i] = (i * 17) % 256;
    single_event(100, 99);
    drain();
    for (int i = 0; i < N; i++) curMap[i] = 0;
    curMap[0] = 255;
    curMap[10] = 255;
    single_event(0, 255);
    drain();

    // R1 inputs changed right after the accept
    for (int i = 0; i < N; i++) curMap[i] = (i * 37) % 230;
    @(negedge clk);
    arm(60, 210, 1'b1);
    @(negedge clk);
    trigAccept = 1'b0;
    lowThr = 8'd0;
    highThr = 8'd1;
    towerEt = '1;
    drain();

    // R8 / R9 burst of accepts on consecutive cycles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 3) check(busy == 1'b1, "R9 busy when full", int'(busy), 1);
      for (int i = 0; i < N; i++) curMap[i] = (i * 23 + k * 61) % 256;
      arm(50 + k * 10, 180 + k * 15, k < 3);
    end
    @(negedge clk);
    trigAccept = 1'b0;
    drain();
    check(evOut == evIn, "R9 dropped accept produced no event", evOut, evIn);
    check(busy == 1'b0, "R9 busy released", int'(busy), 0);

    // R8 queue order after the drop
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) curMap[i] = (i * 13 + k * 97) % 256;
      arm(30, 160 + k * 40, 1'b1);
    end
    @(negedge clk);
    trigAccept = 1'b0;
    drain();
    check(evOut == evIn, "R8 queued events emitted", evOut, evIn);

    summary();
    $finish;
  end
endmodule